// File: doc/BRIEF.md
# Reservation-Based Atomic Memory Unit

This block is a small word-addressed shared memory that several requesters reach through one serialising port. Besides plain loads and stores it offers the primitives that software locks and counters are built from. These are a load that places an address reservation, a store that only writes while that reservation survives, an atomic swap, a test-and-set against zero and a fetch-and-increment. Each operation reads and updates memory in one clock, so no other requester can slip between the read and the write.

Every requester owns one reservation slot, which holds an address and a valid bit. A reserving load fills the slot. Any store that actually changes a word clears every slot that points at that word. The conditional store checks the issuer's slot, reports 1 for a write or 0 for a refusal, and empties the slot in both cases. When several ports request at once, a fixed-priority arbiter grants the lowest index, and ports that lose keep their request up.

The controller has two states. ST_IDLE means no reply is pending. ST_REPLY means the operation granted in the previous cycle is presenting its result. The controller moves to ST_REPLY on any cycle with a grant, and to ST_IDLE on any cycle without one, whichever state it is in.

Top module: `llsc_mem_unit`

## Requirements
- R1: A plain load (opcode 0) returns the addressed word. A plain store (opcode 1) writes the word and replies 0.
- R2: A reserving load (opcode 2) returns the addressed word and records that address, marked valid, in the issuing port's reservation slot.
- R3: A conditional store (opcode 3) writes the word and replies 1 when the issuer's slot is valid and holds the same address.
- R4: A conditional store replies 0 and leaves memory unchanged in three cases: when its reservation was broken by an intervening store to that word, whether from any port or from the issuer itself; when the slot holds a different address; or when no reservation exists.
- R5: A conditional store empties the issuer's slot whether it succeeds or fails, so a repeated conditional store without a new reserving load replies 0.
- R6: A swap (opcode 4) writes the port's data and returns the previous word.
- R7: A test-and-set (opcode 5) returns the previous word and writes the port's data only if that word was zero. A failing test-and-set writes nothing and breaks no reservation.
- R8: A fetch-and-increment (opcode 6) returns the previous word and stores that word plus one, wrapping from all-ones to zero.
- R9: Requests that arrive together are granted one per cycle, lowest port index first. The grant vector is never more than one-hot and never grants a port that is not requesting.
- R10: Two ports that swap 1 into the same free lock word in the same cycle receive 0 and 1, and the word ends at 1.
- R11: The reply, carried on rsp_valid and rsp_data, appears in exactly the cycle after the grant, and only to the granted port.
- R12: After reset all words read 0, all reservations are empty and no reply is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NPORTS | Request per port, held until granted |
| op_in | input | 3*NPORTS | Opcode per port, 3 bits each |
| addr_in | input | AW*NPORTS | Word address per port |
| wdata_in | input | DW*NPORTS | Store, swap or set data per port |
| gnt | output | NPORTS | Grant; the operation executes at the next edge |
| rsp_valid | output | NPORTS | Reply strobe, one cycle after the grant |
| rsp_data | output | DW | Reply value for the port strobed in rsp_valid |

## Verification
Two functions can land in the same cycle. In the first, the arbiter picks between simultaneous requests while the winner's write breaks the loser's reservation. In the second, both ports race to acquire the same lock. The bench raises both requests on one clock edge, for two conditional stores on a word that both ports have reserved and for two swaps of 1 into a free lock. It checks the grant vector before and after the winner drops out. The scoreboard then expects the winner to see success or 0 and the loser to see failure or 1. A final load checks that the word holds only the winner's value.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_LL    = 3'd2,
        OP_SC    = 3'd3,
        OP_SWAP  = 3'd4,
        OP_TAS   = 3'd5,
        OP_FAI   = 3'd6,
        OP_RSVD  = 3'd7
    } op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } st_e;
endpackage

// File: rtl/llsc_arbiter.sv
module llsc_arbiter #(
    parameter int N  = 2,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic          gnt_any,
    output logic [IW-1:0] gnt_idx
);
    for (genvar i = 0; i < N; i++) begin : g_pri
        if (i == 0) begin : g_first
            assign gnt[0] = req[0];
        end else begin : g_rest
            assign gnt[i] = req[i] & ~(|req[i-1:0]);
        end
    end

    assign gnt_any = |req;

    always_comb begin
        gnt_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (gnt[i]) gnt_idx = IW'(i);
        end
    end

    // R9: at most one grant, and only to a requester
    a_r9_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    a_r9_gnt_only_req: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
endmodule

// File: rtl/llsc_exec.sv
module llsc_exec
    import llsc_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_e           op,
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] wdata,
    input  logic          link_ok,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic [DW-1:0] rdata
);
    always_comb begin
        wr_en   = 1'b0;
        wr_data = wdata;
        rdata   = old_val;
        unique case (op)
            OP_LOAD:  rdata = old_val;
            OP_STORE: begin wr_en = 1'b1; rdata = '0; end
            OP_LL:    rdata = old_val;
            OP_SC: begin
                wr_en = link_ok;
                rdata = link_ok ? DW'(1) : '0;
            end
            OP_SWAP:  wr_en = 1'b1;
            OP_TAS:   wr_en = (old_val == '0);
            OP_FAI: begin
                wr_en   = 1'b1;
                wr_data = old_val + 1'b1;
            end
            default:  rdata = old_val;
        endcase
    end
endmodule

// File: rtl/llsc_links.sv
module llsc_links
    import llsc_pkg::*;
#(
    parameter int N  = 2,
    parameter int AW = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gnt_any,
    input  logic [IW-1:0] gnt_idx,
    input  op_e           op,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    output logic          link_ok
);
    logic [N-1:0]  vld;
    logic [AW-1:0] ladr [N];

    assign link_ok = vld[gnt_idx] && (ladr[gnt_idx] == addr);

    for (genvar q = 0; q < N; q++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[q]  <= 1'b0;
                ladr[q] <= '0;
            end else if (gnt_any) begin
                if (gnt_idx == IW'(q) && op == OP_LL) begin
                    vld[q]  <= 1'b1;
                    ladr[q] <= addr;
                end else if (gnt_idx == IW'(q) && op == OP_SC) begin
                    vld[q] <= 1'b0;
                end else if (wr_en && ladr[q] == addr) begin
                    vld[q] <= 1'b0;
                end
            end
        end

        // R4: after a write, no slot still reserves the written word
        a_r4_write_breaks: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_any && wr_en) |=> !(vld[q] && ladr[q] == $past(addr)));
    end

    // R5: a conditional store leaves its issuer without a reservation
    a_r5_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_any && op == OP_SC) |=> !vld[$past(gnt_idx)]);
    // R2: a reserving load leaves a valid slot on its address
    a_r2_ll_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_any && op == OP_LL) |=> (vld[$past(gnt_idx)] && ladr[$past(gnt_idx)] == $past(addr)));
endmodule

// File: rtl/llsc_mem_unit.sv
module llsc_mem_unit
    import llsc_pkg::*;
#(
    parameter int NPORTS = 2,
    parameter int AW     = 4,
    parameter int DW     = 8,
    localparam int DEPTH = 1 << AW,
    localparam int IW    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPORTS-1:0]    req,
    input  logic [3*NPORTS-1:0]  op_in,
    input  logic [AW*NPORTS-1:0] addr_in,
    input  logic [DW*NPORTS-1:0] wdata_in,
    output logic [NPORTS-1:0]    gnt,
    output logic [NPORTS-1:0]    rsp_valid,
    output logic [DW-1:0]        rsp_data
);
    logic          gnt_any;
    logic [IW-1:0] gnt_idx;
    op_e           sel_op;
    logic [AW-1:0] sel_addr;
    logic [DW-1:0] sel_wdata;
    logic [DW-1:0] old_val;
    logic          link_ok;
    logic          wr_en;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] ex_rdata;
    logic [DW-1:0] mem [DEPTH];
    st_e           state;
    logic [IW-1:0] resp_port;

    llsc_arbiter #(.N(NPORTS)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req),
        .gnt(gnt), .gnt_any(gnt_any), .gnt_idx(gnt_idx)
    );

    always_comb begin
        sel_op    = op_e'(op_in[gnt_idx*3 +: 3]);
        sel_addr  = addr_in[gnt_idx*AW +: AW];
        sel_wdata = wdata_in[gnt_idx*DW +: DW];
        old_val   = mem[sel_addr];
    end

    llsc_links #(.N(NPORTS), .AW(AW)) u_links (
        .clk(clk), .rst_n(rst_n), .gnt_any(gnt_any), .gnt_idx(gnt_idx),
        .op(sel_op), .addr(sel_addr), .wr_en(wr_en), .link_ok(link_ok)
    );

    llsc_exec #(.DW(DW)) u_exec (
        .op(sel_op), .old_val(old_val), .wdata(sel_wdata), .link_ok(link_ok),
        .wr_en(wr_en), .wr_data(wr_data), .rdata(ex_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (gnt_any && wr_en) begin
            mem[sel_addr] <= wr_data;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:  state <= gnt_any ? ST_REPLY : ST_IDLE;
                ST_REPLY: state <= gnt_any ? ST_REPLY : ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_port <= '0;
            rsp_data  <= '0;
        end else if (gnt_any) begin
            resp_port <= gnt_idx;
            rsp_data  <= ex_rdata;
        end
    end

    always_comb begin
        for (int p = 0; p < NPORTS; p++)
            rsp_valid[p] = (state == ST_REPLY) && (resp_port == IW'(p));
    end

    // R11: reply strobe mirrors the previous cycle's grant
    a_r11_reply_follows_grant: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rsp_valid == $past(gnt));
    // R7: a failing test-and-set leaves the word alone
    a_r7_tas_fail_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_any && sel_op == OP_TAS && old_val != '0) |=> mem[$past(sel_addr)] == $past(old_val));
    // R8: fetch-and-increment stores old plus one
    a_r8_fai_adds: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_any && sel_op == OP_FAI) |=> mem[$past(sel_addr)] == DW'($past(old_val) + 1'b1));
    // R3: a conditional store on an intact reservation replies 1
    a_r3_sc_reply: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_any && sel_op == OP_SC && link_ok) |=> rsp_data == DW'(1));
endmodule

// File: tb/tb_llsc_mem_unit.sv
module tb_llsc_mem_unit;
    import llsc_pkg::*;

    localparam int N  = 2;
    localparam int AW = 4;
    localparam int DW = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     req = '0;
    logic [3*N-1:0]   op = '0;
    logic [AW*N-1:0]  addr = '0;
    logic [DW*N-1:0]  wdata = '0;
    logic [N-1:0]     gnt;
    logic [N-1:0]     rsp_valid;
    logic [DW-1:0]    rsp_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int            port;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;
    exp_t sb[$];
    exp_t cur;

    always #2 clk = ~clk;

    llsc_mem_unit #(.NPORTS(N), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .op_in(op), .addr_in(addr),
        .wdata_in(wdata), .gnt(gnt), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic setp(int p, op_e o, int a, int d);
        op[p*3 +: 3]     = o;
        addr[p*AW +: AW] = AW'(a);
        wdata[p*DW +: DW] = DW'(d);
        req[p] = 1'b1;
    endtask

    task automatic push(int p, int d, string tag);
        exp_t e;
        e.port = p; e.data = DW'(d); e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic run1(int p, op_e o, int a, int d, int e, string tag);
        @(negedge clk);
        setp(p, o, a, d);
        push(p, e, tag);
        #1;
        while (!gnt[p]) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        req[p] = 1'b0;
    endtask

    task automatic run2(op_e o0, int a0, int d0, int e0,
                        op_e o1, int a1, int d1, int e1, string tag);
        @(negedge clk);
        setp(0, o0, a0, d0);
        setp(1, o1, a1, d1);
        push(0, e0, tag);
        push(1, e1, tag);
        #1;
        chk(gnt == 2'b01, "R9 low index first", int'(gnt), 1);
        @(posedge clk); #1;
        req[0] = 1'b0;
        #1;
        chk(gnt == 2'b10, "R9 waiting port granted next", int'(gnt), 2);
        @(posedge clk); #1;
        req[1] = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < N; p++) begin
                if (rsp_valid[p]) begin
                    if (sb.size() == 0) begin
                        chk(1'b0, "R11 unexpected reply", p, -1);
                    end else begin
                        cur = sb.pop_front();
                        chk(cur.port == p && rsp_data == cur.data, cur.tag,
                            p * 256 + int'(rsp_data), cur.port * 256 + int'(cur.data));
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R11 watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rsp_valid == '0, "R12 no reply in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == '0, "R12 no reply after reset", int'(rsp_valid), 0);

        run1(0, OP_LOAD, 3, 0, 8'h00, "R12 memory cleared");
        run1(0, OP_STORE, 1, 8'h10, 8'h00, "R1 store replies 0");
        run1(1, OP_LOAD, 1, 0, 8'h10, "R1 load sees store");

        run1(0, OP_LL, 1, 0, 8'h10, "R2 reserving load value");
        run1(0, OP_SC, 1, 8'h11, 8'h01, "R3 intact reservation succeeds");
        run1(1, OP_LOAD, 1, 0, 8'h11, "R3 conditional store wrote");
        run1(0, OP_SC, 1, 8'h22, 8'h00, "R5 repeated conditional store fails");
        run1(1, OP_LOAD, 1, 0, 8'h11, "R5 memory unchanged");

        run1(0, OP_LL, 2, 0, 8'h00, "R2 reserve word 2");
        run1(1, OP_STORE, 2, 8'h05, 8'h00, "R4 other port store");
        run1(0, OP_SC, 2, 8'h07, 8'h00, "R4 broken by other port");
        run1(0, OP_LOAD, 2, 0, 8'h05, "R4 memory unchanged");

        run1(1, OP_LL, 4, 0, 8'h00, "R2 reserve word 4");
        run1(1, OP_SC, 5, 8'h09, 8'h00, "R4 address mismatch fails");
        run1(1, OP_LOAD, 5, 0, 8'h00, "R4 mismatch wrote nothing");
        run1(1, OP_SC, 6, 8'h09, 8'h00, "R4 no reservation fails");

        run1(0, OP_LL, 13, 0, 8'h00, "R2 reserve word 13");
        run1(0, OP_STORE, 13, 8'h05, 8'h00, "R4 own plain store");
        run1(0, OP_SC, 13, 8'h06, 8'h00, "R4 own store breaks reservation");

        run1(0, OP_SWAP, 7, 8'h3C, 8'h00, "R6 swap returns old");
        run1(1, OP_LOAD, 7, 0, 8'h3C, "R6 swap wrote new");

        run1(1, OP_TAS, 8, 8'h01, 8'h00, "R7 set on zero");
        run1(1, OP_TAS, 8, 8'h02, 8'h01, "R7 non-zero returns old");
        run1(0, OP_LOAD, 8, 0, 8'h01, "R7 failing test wrote nothing");
        run1(0, OP_LL, 8, 0, 8'h01, "R2 reserve word 8");
        run1(1, OP_TAS, 8, 8'h05, 8'h01, "R7 failing test again");
        run1(0, OP_SC, 8, 8'h09, 8'h01, "R7 failing test kept reservation");
        run1(1, OP_LOAD, 8, 0, 8'h09, "R7 conditional store landed");

        run1(0, OP_FAI, 9, 0, 8'h00, "R8 first increment");
        run1(1, OP_FAI, 9, 0, 8'h01, "R8 second increment");
        run1(0, OP_LOAD, 9, 0, 8'h02, "R8 counter value");
        run1(0, OP_STORE, 10, 8'hFF, 8'h00, "R1 store all-ones");
        run1(1, OP_FAI, 10, 0, 8'hFF, "R8 increment at top");
        run1(0, OP_LOAD, 10, 0, 8'h00, "R8 wrap to zero");

        run2(OP_LL, 11, 0, 8'h00, OP_LL, 11, 0, 8'h00, "R2 both reserve");
        run2(OP_SC, 11, 8'h44, 8'h01, OP_SC, 11, 8'h55, 8'h00, "R3 R4 conditional race");
        run1(1, OP_LOAD, 11, 0, 8'h44, "R4 only winner wrote");

        run2(OP_SWAP, 12, 8'h01, 8'h00, OP_SWAP, 12, 8'h01, 8'h01, "R10 lock race");
        run1(0, OP_LOAD, 12, 0, 8'h01, "R10 lock held");

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R11 every reply arrived", sb.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule